// File: doc/BRIEF.md
# Digital Loss-of-Signal Detector

This block watches the recovered, decoded bit stream of a line receiver and keeps a sticky flag that reports a digital loss of signal. A long run of consecutive zeros raises the flag. It falls again only when the stream has shown enough marks: a set number of ones must arrive within a bounded number of bits. Setting and clearing therefore follow different rules, and the flag does not chatter when the stream is marginal.

Bits are offered one at a time with a qualifying strobe. Cycles without the strobe are gaps in the stream and have no effect. An amplitude-based loss indication comes from elsewhere in the receiver. It enters as a plain input and is ORed with the digital flag to give a single alarm.

Top module: `dlos_monitor`

## Requirements
- R1: While reset (active-low `rst_n`) is asserted and after it is released, `dlos` is 0 until a qualifying zero run occurs.
- R2: `dlos` goes to 1 on the clock edge that accepts the ZERO_RUN-th consecutive accepted zero (default 175). A run of ZERO_RUN-1 zeros followed by a one leaves it at 0.
- R3: A cycle with `bit_vld` low is ignored. It does not count as a zero or a one, it does not break a zero run, and it does not change `dlos`.
- R4: Once set, `dlos` stays at 1 until the clear rule of R5 is met. Sparse ones and further zeros do not clear it.
- R5: While `dlos` is 1, a density window begins with the first accepted bit after the set, or after a restart. `dlos` returns to 0 on the edge that accepts the CLR_PULSES-th one of the window (default 175), provided that bit is at most position 3*CLR_PULSES-1 in the window (default 524). Pattern 1,0,0 repeated clears. Pattern 0,0,1 repeated does not.
- R6: If the window reaches 3*CLR_PULSES accepted bits without clearing, it restarts empty with the next bit. Ones counted before the restart are lost.
- R7: While `dlos` is 1, a new zero run that reaches ZERO_RUN restarts the window. Ones seen before that run do not count toward clearing.
- R8: `alarm` is 1 whenever `alos_in` or `dlos` is 1, and 0 otherwise, in the same cycle with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_vld | input | 1 | Qualifies `bit_in` in this cycle |
| bit_in | input | 1 | Decoded line bit, 1 means a mark |
| alos_in | input | 1 | Amplitude-based loss indication from the analog side |
| dlos | output | 1 | Sticky digital loss-of-signal flag |
| alarm | output | 1 | OR of `dlos` and `alos_in` |

## Verification
The hardest cases to reach are the exact edges of the clear window: a CLR_PULSES-th one that lands at the last allowed bit position, and one that lands a single bit too late. Both also have to be told apart from a restart caused by a fresh zero run partway through the window. Directed sequences cover each of these. Repeated 1,0,0 and 0,0,1 patterns place the final one at positions 523 and 525. A burst of ones followed by a full zero run shows that earlier marks are discarded. The random part of the stimulus is built from segments of fixed mark probability, with valid gaps mixed in, so that sets, failed windows and clears all recur many times.

// File: rtl/dlos_pkg.sv
package dlos_pkg;

  typedef enum logic {
    ST_SIGNAL = 1'b0,
    ST_LOST   = 1'b1
  } dlos_state_e;

  // bits allowed in one clear window
  function automatic int unsigned window_bit_limit(int unsigned pulses, int unsigned ratio);
    return pulses * ratio;
  endfunction

  // window succeeds when the required marks arrive before the bit limit
  function automatic logic window_met(int unsigned ones, int unsigned bits,
                                      int unsigned pulses, int unsigned limit);
    return (ones == pulses) && (bits < limit);
  endfunction

  // next length of a saturating zero run
  function automatic int unsigned run_next(int unsigned cur, logic mark, int unsigned sat);
    if (mark) return 0;
    if (cur >= sat) return sat;
    return cur + 1;
  endfunction

endpackage

// File: rtl/dlos_zero_run.sv
module dlos_zero_run #(
  parameter int unsigned ZERO_RUN = 175,
  localparam int unsigned RUN_W = $clog2(ZERO_RUN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_in,
  output logic run_hit
);
  import dlos_pkg::*;

  logic [RUN_W-1:0] run_len;

  // fires once per run, on the zero that completes the threshold
  assign run_hit = bit_vld && !bit_in && (run_len == RUN_W'(ZERO_RUN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= '0;
    end else if (bit_vld) begin
      run_len <= RUN_W'(run_next(int'(run_len), bit_in, ZERO_RUN));
    end
  end

endmodule

// File: rtl/dlos_density_window.sv
module dlos_density_window #(
  parameter int unsigned CLR_PULSES = 175,
  parameter int unsigned RATIO      = 3,
  localparam int unsigned BIT_LIM = CLR_PULSES * RATIO,
  localparam int unsigned ONES_W  = $clog2(CLR_PULSES + 1),
  localparam int unsigned BITS_W  = $clog2(BIT_LIM + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              restart,
  input  logic              bit_vld,
  input  logic              bit_in,
  output logic              win_pass,
  output logic              win_full,
  output logic [ONES_W-1:0] win_ones,
  output logic [BITS_W-1:0] win_bits
);
  import dlos_pkg::*;

  int unsigned ones_nx;
  int unsigned bits_nx;
  logic        take;

  assign take    = active && bit_vld && !restart;
  assign ones_nx = int'(win_ones) + (bit_in ? 1 : 0);
  assign bits_nx = int'(win_bits) + 1;

  assign win_pass = take && bit_in &&
                    window_met(ones_nx, bits_nx, CLR_PULSES,
                               window_bit_limit(CLR_PULSES, RATIO));
  assign win_full = take && !win_pass && (bits_nx == BIT_LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_ones <= '0;
      win_bits <= '0;
    end else if (!active || restart || win_pass || win_full) begin
      win_ones <= '0;
      win_bits <= '0;
    end else if (bit_vld) begin
      win_ones <= ONES_W'(ones_nx);
      win_bits <= BITS_W'(bits_nx);
    end
  end

endmodule

// File: rtl/dlos_flag.sv
module dlos_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic run_hit,
  input  logic win_pass,
  output logic lost
);
  import dlos_pkg::*;

  dlos_state_e state, state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_SIGNAL: if (run_hit)  state_nx = ST_LOST;
      ST_LOST:   if (win_pass) state_nx = ST_SIGNAL;
      default:   state_nx = ST_SIGNAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_SIGNAL;
    else        state <= state_nx;
  end

  assign lost = (state == ST_LOST);

endmodule

// File: rtl/dlos_monitor.sv
module dlos_monitor #(
  parameter int unsigned ZERO_RUN   = 175,
  parameter int unsigned CLR_PULSES = 175,
  parameter int unsigned RATIO      = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_in,
  input  logic alos_in,
  output logic dlos,
  output logic alarm
);
  localparam int unsigned BIT_LIM = CLR_PULSES * RATIO;
  localparam int unsigned ONES_W  = $clog2(CLR_PULSES + 1);
  localparam int unsigned BITS_W  = $clog2(BIT_LIM + 1);

  generate
    if (ZERO_RUN < 100 || ZERO_RUN > 250 || CLR_PULSES < 100 || CLR_PULSES > 250) begin : g_bad_cfg
      $error("dlos_monitor: thresholds must lie in 100..250");
    end
  endgenerate

  logic              run_hit;
  logic              win_pass;
  logic              win_full;
  logic [ONES_W-1:0] win_ones;
  logic [BITS_W-1:0] win_bits;

  dlos_zero_run #(.ZERO_RUN(ZERO_RUN)) u_run (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_vld (bit_vld),
    .bit_in  (bit_in),
    .run_hit (run_hit)
  );

  dlos_density_window #(.CLR_PULSES(CLR_PULSES), .RATIO(RATIO)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (dlos),
    .restart  (run_hit),
    .bit_vld  (bit_vld),
    .bit_in   (bit_in),
    .win_pass (win_pass),
    .win_full (win_full),
    .win_ones (win_ones),
    .win_bits (win_bits)
  );

  dlos_flag u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_hit  (run_hit),
    .win_pass (win_pass),
    .lost     (dlos)
  );

  assign alarm = dlos | alos_in;

endmodule

// File: rtl/dlos_checker.sv
module dlos_checker #(
  parameter int unsigned BIT_LIM = 525,
  parameter int unsigned ONES_W  = 8,
  parameter int unsigned BITS_W  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_vld,
  input logic              bit_in,
  input logic              alos_in,
  input logic              dlos,
  input logic              alarm,
  input logic              run_hit,
  input logic              win_pass,
  input logic              win_full,
  input logic [ONES_W-1:0] win_ones,
  input logic [BITS_W-1:0] win_bits
);

  assert_set_on_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_hit |=> dlos);

  assert_no_set_without_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!dlos && !run_hit) |=> !dlos);

  assert_gap_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> $stable(dlos));

  assert_clear_on_mark_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dlos) |-> $past(bit_vld && bit_in));

  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dlos && !win_pass) |=> dlos);

  assert_window_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(win_bits) < BIT_LIM);

  assert_full_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    win_full |=> (win_bits == '0 && win_ones == '0 && dlos));

  assert_rearm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dlos && run_hit) |=> (win_bits == '0 && win_ones == '0 && dlos));

  assert_alarm_analog_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alos_in |-> alarm);

  assert_alarm_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!alos_in && !dlos) |-> !alarm);

endmodule

bind dlos_monitor dlos_checker #(.BIT_LIM(BIT_LIM), .ONES_W(ONES_W), .BITS_W(BITS_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bit_vld  (bit_vld),
  .bit_in   (bit_in),
  .alos_in  (alos_in),
  .dlos     (dlos),
  .alarm    (alarm),
  .run_hit  (run_hit),
  .win_pass (win_pass),
  .win_full (win_full),
  .win_ones (win_ones),
  .win_bits (win_bits)
);

// File: tb/sim_dlos_monitor.sv
`timescale 1ns/100ps
module sim_dlos_monitor;
  localparam int ZR  = 175;
  localparam int CP  = 175;
  localparam int LIM = 3 * CP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_vld = 1'b0;
  logic bit_in = 1'b0;
  logic alos_in = 1'b0;
  logic dlos;
  logic alarm;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // reference state, kept from the requirements
  int m_run = 0;
  int m_ones = 0;
  int m_bits = 0;
  bit m_los = 1'b0;

  always #2.5 clk = ~clk;

  dlos_monitor u0 (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
    .alos_in(alos_in), .dlos(dlos), .alarm(alarm)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // advance reference by one accepted or ignored cycle
  task automatic model(bit v, bit b);
    bit hit;
    if (!v) return;
    hit = !b && (m_run == ZR - 1);
    m_run = b ? 0 : ((m_run >= ZR) ? ZR : m_run + 1);
    if (!m_los) begin
      if (hit) begin m_los = 1'b1; m_ones = 0; m_bits = 0; end
    end else if (hit) begin
      m_ones = 0; m_bits = 0;
    end else begin
      m_bits++;
      if (b) m_ones++;
      if (b && m_ones == CP && m_bits < LIM) begin
        m_los = 1'b0; m_ones = 0; m_bits = 0;
      end else if (m_bits == LIM) begin
        m_ones = 0; m_bits = 0;
      end
    end
  endtask

  // inputs change 1ns after a rising edge; outputs sampled 1ns after the next
  task automatic step(bit v, bit b, bit a, string req);
    bit_vld = v; bit_in = b; alos_in = a;
    @(posedge clk); #1;
    model(v, b);
    check(req, int'(dlos), int'(m_los));
    check("R8", int'(alarm), int'(m_los | a));
  endtask

  task automatic zeros(int n, string req);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, req);
  endtask

  task automatic ones(int n, string req);
    for (int i = 0; i < n; i++) step(1'b1, 1'b1, 1'b0, req);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    int seg_len;
    int pct;
    bit b;
    bit v;
    bit a;
    void'($urandom(32'd1409));
    #1;
    check("R1", int'(dlos), 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", int'(dlos), 0);

    // R2: one short of the run, then a mark
    zeros(ZR - 1, "R2");
    ones(1, "R2");
    check("R2", int'(dlos), 0);
    // R3: gaps carrying marks do not break a run
    zeros(100, "R3");
    for (int i = 0; i < 50; i++) step(1'b0, 1'b1, 1'b0, "R3");
    zeros(ZR - 101, "R3");
    check("R3", int'(dlos), 0);
    zeros(1, "R2");
    check("R2", int'(dlos), 1);
    // R3: ignored marks while lost
    for (int i = 0; i < CP; i++) step(1'b0, 1'b1, 1'b0, "R3");
    check("R3", int'(dlos), 1);
    // R6: 0,0,1 puts the last mark at position 525 -> restart, still lost
    for (int i = 0; i < CP; i++) begin
      step(1'b1, 1'b0, 1'b0, "R6"); step(1'b1, 1'b0, 1'b0, "R6"); step(1'b1, 1'b1, 1'b0, "R6");
    end
    check("R6", int'(dlos), 1);
    // R5: 1,0,0 puts the last mark at position 523 -> clears there
    for (int i = 0; i < CP - 1; i++) begin
      step(1'b1, 1'b1, 1'b0, "R5"); step(1'b1, 1'b0, 1'b0, "R5"); step(1'b1, 1'b0, 1'b0, "R5");
    end
    check("R5", int'(dlos), 1);
    ones(1, "R5");
    check("R5", int'(dlos), 0);

    // R7: marks before a fresh run are discarded
    zeros(ZR, "R7");
    check("R7", int'(dlos), 1);
    ones(100, "R4");
    zeros(ZR, "R7");
    ones(75, "R7");
    check("R7", int'(dlos), 1);
    ones(CP - 76, "R7");
    check("R7", int'(dlos), 1);
    ones(1, "R7");
    check("R7", int'(dlos), 0);

    // R8: analog loss alone drives the alarm
    step(1'b1, 1'b1, 1'b1, "R8");
    check("R8", int'(alarm), 1);
    check("R8", int'(dlos), 0);
    step(1'b1, 1'b1, 1'b0, "R8");
    check("R8", int'(alarm), 0);

    // R4: sparse marks while lost
    zeros(ZR, "R4");
    for (int i = 0; i < 600; i++) step(1'b1, (i % 10) == 0, 1'b0, "R4");
    check("R4", int'(dlos), 1);

    // random segments of fixed mark probability
    for (int s = 0; s < 60; s++) begin
      seg_len = 50 + int'($urandom_range(650));
      case ($urandom_range(5))
        0: pct = 0;
        1: pct = 2;
        2: pct = 15;
        3: pct = 40;
        4: pct = 70;
        default: pct = 100;
      endcase
      for (int i = 0; i < seg_len; i++) begin
        v = ($urandom_range(99) < 85);
        b = ($urandom_range(99) < pct);
        a = ($urandom_range(99) < 5);
        step(v, b, a, "R5");
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule